// File: doc/BRIEF.md
# Legacy Video Range Forwarding Decoder

This block decides whether a single bridge access targets the legacy video apertures and so has to be claimed. These apertures are claimed whatever the normal base/limit windows say. The decoder checks a 64-bit address against one memory window and two I/O windows. It also applies the memory-space and I/O-space enables, the forwarding enable and the 16-bit I/O decode option, and the direction the access travels.

An access is presented for one cycle with `req_valid` high. One clock edge later the decision appears on `claim`, and `claim_vld` marks that cycle.

Direction is handled as follows:
- A downstream access (arriving on the primary side) is claimed only while forwarding is on.
- An upstream access (arriving on the secondary side) is claimed only while forwarding is off. In that case the secondary bus keeps these ranges for the primary side.

Top module: `vga_fwd_decoder`

## Requirements
- R1: With `req_space` = 2'b01 (memory), an address from 0x000A0000 through 0x000BFFFF inclusive is claimed (direction and enables permitting). Every other 64-bit address is not claimed.
- R2: With `req_space` = 2'b10 (I/O), address bits 9:0 must fall in 0x3B0–0x3BB or in 0x3C0–0x3DF for a claim. 0x3BC–0x3BF, 0x3AF and 0x3E0 are not claimed.
- R3: An I/O access with any of address bits 63:16 set is never claimed.
- R4: When 16-bit decode is not in force, I/O address bits 15:10 are ignored, so the I/O windows repeat every 1 KB.
- R5: 16-bit decode is in force only when `dec16_en` and `fwd_en` are both 1. In that case an I/O access is claimed only if bits 15:10 are zero.
- R6: A memory access is claimed only when `mem_en` is 1, and an I/O access only when `io_en` is 1.
- R7: With `from_sec` = 0, a hit is claimed only when `fwd_en` = 1. With `from_sec` = 1, a hit is claimed only when `fwd_en` = 0.
- R8: `claim_vld` is high in exactly the cycle after a cycle with `req_valid` high, and carries that request's decision. When `claim_vld` is low, `claim` is low.
- R9: `req_space` codes 2'b00 and 2'b11 are never claimed.
- R10: After synchronous reset, `claim` and `claim_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per high cycle |
| req_addr | input | 64 | Access address |
| req_space | input | 2 | 01 memory, 10 I/O, 00/11 unknown |
| fwd_en | input | 1 | Legacy video forwarding enable |
| dec16_en | input | 1 | Full 16-bit I/O decode request |
| mem_en | input | 1 | Memory space enable |
| io_en | input | 1 | I/O space enable |
| from_sec | input | 1 | 1 when the access arrives on the secondary side |
| claim | output | 1 | Registered claim decision |
| claim_vld | output | 1 | Marks the cycle carrying a decision |

## Verification
The assertions assume that every request field and enable is at a known level in any cycle with `req_valid` high. They also assume the enables are sampled with the request in that same cycle, not held from an earlier one. The bench drives all inputs together on the falling edge, so each request sees one consistent set of inputs. Addresses are biased toward the window edges and the 1 KB alias images, with the upper bits occasionally set. Space codes and all enables are drawn at random.

// File: rtl/vga_fwd_pkg.sv
package vga_fwd_pkg;

  typedef enum logic [1:0] {
    SP_NONE = 2'b00,
    SP_MEM  = 2'b01,
    SP_IO   = 2'b10,
    SP_RSVD = 2'b11
  } space_e;

  localparam int IO_WIN_N = 2;

  // Low-10-bit I/O windows; index 0 is the mono block, index 1 the colour block
  function automatic logic [9:0] io_win_lo(input int idx);
    return (idx == 0) ? 10'h3B0 : 10'h3C0;
  endfunction

  function automatic logic [9:0] io_win_hi(input int idx);
    return (idx == 0) ? 10'h3BB : 10'h3DF;
  endfunction

endpackage

// File: rtl/vga_mem_match.sv
module vga_mem_match #(
  parameter int          ADDR_W = 64,
  parameter logic [63:0] WIN_LO = 64'h000A_0000,
  parameter logic [63:0] WIN_HI = 64'h000B_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LO = WIN_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] HI = WIN_HI[ADDR_W-1:0];

  always_comb hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/vga_io_match.sv
module vga_io_match
  import vga_fwd_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int ALIAS_W = 10,
  parameter int SPAN_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strict,
  output logic              hit
);
  localparam int GAP_W = SPAN_W - ALIAS_W;

  logic [IO_WIN_N-1:0] win_hit;
  logic                upper_zero;
  logic                gap_zero;
  logic [ALIAS_W-1:0]  low;

  always_comb begin
    low        = addr[ALIAS_W-1:0];
    upper_zero = (addr[ADDR_W-1:SPAN_W] == '0);
    gap_zero   = (addr[SPAN_W-1:ALIAS_W] == {GAP_W{1'b0}});
  end

  for (genvar gi = 0; gi < IO_WIN_N; gi++) begin : g_win
    localparam logic [ALIAS_W-1:0] LO = ALIAS_W'(io_win_lo(gi));
    localparam logic [ALIAS_W-1:0] HI = ALIAS_W'(io_win_hi(gi));
    always_comb win_hit[gi] = (low >= LO) && (low <= HI);
  end

  always_comb hit = upper_zero && (|win_hit) && (!strict || gap_zero);
endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder
  import vga_fwd_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int ALIAS_W = 10,
  parameter int SPAN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_space,
  input  logic              fwd_en,
  input  logic              dec16_en,
  input  logic              mem_en,
  input  logic              io_en,
  input  logic              from_sec,
  output logic              claim,
  output logic              claim_vld
);
  space_e sp;
  logic   mem_hit, io_hit, strict16, dir_ok, claim_d;
  logic   claim_q, vld_q;

  vga_mem_match #(.ADDR_W(ADDR_W)) u_mem (
    .addr (req_addr),
    .hit  (mem_hit)
  );

  vga_io_match #(.ADDR_W(ADDR_W), .ALIAS_W(ALIAS_W), .SPAN_W(SPAN_W)) u_io (
    .addr   (req_addr),
    .strict (strict16),
    .hit    (io_hit)
  );

  always_comb begin
    sp       = space_e'(req_space);
    strict16 = fwd_en & dec16_en;
    dir_ok   = from_sec ? ~fwd_en : fwd_en;
    unique case (sp)
      SP_MEM:  claim_d = dir_ok & mem_en & mem_hit;
      SP_IO:   claim_d = dir_ok & io_en & io_hit;
      default: claim_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q   <= req_valid;
      claim_q <= req_valid & claim_d;
    end
  end

  assign claim     = claim_q;
  assign claim_vld = vld_q;
endmodule

// File: rtl/vga_fwd_chk.sv
module vga_fwd_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_space,
  input logic              fwd_en,
  input logic              mem_en,
  input logic              io_en,
  input logic              from_sec,
  input logic              claim,
  input logic              claim_vld
);
  p_vld_rise_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> claim_vld);
  p_vld_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !claim_vld);
  p_quiet_claim_r8: assert property (@(posedge clk) disable iff (rst)
    !claim_vld |-> !claim);
  p_unknown_space_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_space == 2'b00 || req_space == 2'b11)) |=> !claim);
  p_mem_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_space == 2'b01 && !mem_en) |=> !claim);
  p_io_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_space == 2'b10 && !io_en) |=> !claim);
  p_io_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_space == 2'b10 && req_addr[ADDR_W-1:16] != '0) |=> !claim);
  p_down_off_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !from_sec && !fwd_en) |=> !claim);
  p_up_on_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && from_sec && fwd_en) |=> !claim);
endmodule

bind vga_fwd_decoder vga_fwd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_space (req_space),
  .fwd_en    (fwd_en),
  .mem_en    (mem_en),
  .io_en     (io_en),
  .from_sec  (from_sec),
  .claim     (claim),
  .claim_vld (claim_vld)
);

// File: tb/sim_vga_fwd_decoder.sv
`timescale 1ns/1ps
module sim_vga_fwd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_space = 2'b00;
  logic        fwd_en = 1'b0, dec16_en = 1'b0, mem_en = 1'b0, io_en = 1'b0, from_sec = 1'b0;
  logic        claim, claim_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vga_fwd_decoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_space(req_space), .fwd_en(fwd_en), .dec16_en(dec16_en),
    .mem_en(mem_en), .io_en(io_en), .from_sec(from_sec),
    .claim(claim), .claim_vld(claim_vld)
  );

  function automatic bit model(input logic [63:0] a, input logic [1:0] s,
                               input bit fw, input bit d16, input bit me,
                               input bit ie, input bit sec);
    bit dir, hit;
    logic [9:0] lo;
    dir = sec ? !fw : fw;
    lo  = a[9:0];
    hit = 1'b0;
    if (s == 2'b01)
      hit = me && (a >= 64'hA0000) && (a <= 64'hBFFFF);
    else if (s == 2'b10)
      hit = ie && (a[63:16] == 48'd0) &&
            ((lo >= 10'h3B0 && lo <= 10'h3BB) || (lo >= 10'h3C0 && lo <= 10'h3DF)) &&
            !(fw && d16 && a[15:10] != 6'd0);
    return dir && hit;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [63:0] a, input logic [1:0] s,
                       input bit fw, input bit d16, input bit me, input bit ie,
                       input bit sec);
    req_valid = 1'b1; req_addr = a; req_space = s;
    fwd_en = fw; dec16_en = d16; mem_en = me; io_en = ie; from_sec = sec;
    @(negedge clk);
    check({req, " vld"}, claim_vld, 1'b1);
    check(req, claim, model(a, s, fw, d16, me, ie, sec));
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check("R10 claim", claim, 1'b0);
    check("R10 vld", claim_vld, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle vld", claim_vld, 1'b0);

    issue("R1 lo edge",  64'hA0000, 2'b01, 1, 0, 1, 1, 0);
    issue("R1 hi edge",  64'hBFFFF, 2'b01, 1, 0, 1, 1, 0);
    issue("R1 below",    64'h9FFFF, 2'b01, 1, 0, 1, 1, 0);
    issue("R1 above",    64'hC0000, 2'b01, 1, 0, 1, 1, 0);
    issue("R1 high bit", 64'h100_000A_0000, 2'b01, 1, 0, 1, 1, 0);
    issue("R2 3B0", 64'h3B0, 2'b10, 1, 0, 1, 1, 0);
    issue("R2 3BB", 64'h3BB, 2'b10, 1, 0, 1, 1, 0);
    issue("R2 3BC", 64'h3BC, 2'b10, 1, 0, 1, 1, 0);
    issue("R2 3AF", 64'h3AF, 2'b10, 1, 0, 1, 1, 0);
    issue("R2 3DF", 64'h3DF, 2'b10, 1, 0, 1, 1, 0);
    issue("R2 3E0", 64'h3E0, 2'b10, 1, 0, 1, 1, 0);
    issue("R3 bit16", 64'h1_03C0, 2'b10, 1, 0, 1, 1, 0);
    issue("R3 bit63", 64'h8000_0000_0000_03C0, 2'b10, 1, 0, 1, 1, 0);
    issue("R4 alias 7B0", 64'h7B0, 2'b10, 1, 0, 1, 1, 0);
    issue("R4 alias FDF", 64'hFFDF, 2'b10, 1, 0, 1, 1, 0);
    issue("R5 strict alias", 64'h7B0, 2'b10, 1, 1, 1, 1, 0);
    issue("R5 strict base", 64'h3C5, 2'b10, 1, 1, 1, 1, 0);
    issue("R5 d16 needs fwd", 64'h7B0, 2'b10, 0, 1, 1, 1, 1);
    issue("R6 mem off", 64'hA8000, 2'b01, 1, 0, 0, 1, 0);
    issue("R6 io off",  64'h3C0, 2'b10, 1, 0, 1, 0, 0);
    issue("R7 down fwd off", 64'hA8000, 2'b01, 0, 0, 1, 1, 0);
    issue("R7 up fwd off",   64'hA8000, 2'b01, 0, 0, 1, 1, 1);
    issue("R7 up fwd on",    64'h3B4, 2'b10, 1, 0, 1, 1, 1);
    issue("R9 space 00", 64'hA0000, 2'b00, 1, 0, 1, 1, 0);
    issue("R9 space 11", 64'h3C0, 2'b11, 1, 0, 1, 1, 0);
    @(negedge clk);
    check("R8 gap vld", claim_vld, 1'b0);
    check("R8 gap claim", claim, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      int m;
      m = $urandom_range(0, 3);
      case (m)
        0: a = 64'hA0000 - 64'h100 + 64'($urandom_range(0, 32'h20200));
        1: a = {48'd0, 6'($urandom), 10'($urandom_range(10'h3A8, 10'h3E8))};
        2: a = {32'($urandom), 32'($urandom)};
        default: a = {16'($urandom_range(0, 1)), 32'd0, 6'($urandom), 10'($urandom)};
      endcase
      issue("R1 R2 R4 R5 R7 random", a, 2'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0), 1'($urandom));
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        check("R8 random idle", claim_vld | claim, 1'b0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule